// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block is the control and data path of a small synchronous SRAM with registered inputs and registered read data. Each rising clock edge samples three chip enables, two address strobes (a processor strobe and a controller strobe), an advance input and the write controls. From these it decides whether the edge starts a read, starts a write, deselects the device, or continues or suspends the access already in progress. Writes can be masked per byte lane. Read data for an address appears on the output one clock after the address is sampled.

The shared data bus is split into an input word, an output word and a drive flag. The drive flag is the tri-state enable for the external pads. It combines the asynchronous active-low output-enable pin with internal masking.

A burst generator inside the block holds the start address and steps the two low address bits in linear or interleaved order. A sleep input gates all accesses after a two-edge delay. Memory contents are kept while asleep.

Top module: `sram_access_ctrl`

## Requirements
- R1: The device is selected when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An edge with a recognised strobe while the device is not selected ends any access. `dq_drive` is then 0 from that edge on, until a new read completes. An edge with no strobe while the device is idle keeps it idle.
- R2: A read address sampled at edge k is read from the array at edge k+1. After edge k+1, `rdata` holds that word, and `dq_drive` is 1 if the cycle after edge k+1 is also a read and `drv_en_n`=0.
- R3: After a read-start edge that follows an idle cycle or a write cycle, `dq_drive` stays 0 for one cycle, whatever `drv_en_n` is.
- R4: A processor-strobe start always begins a read and ignores `all_wr_n`, `lane_wr_n`, `lane_sel_n` and `burst_adv_n`. A write to that address then happens at the next edge, if both strobes are high and the write controls are active there.
- R5: A controller-strobe start with `cpu_stb_n`=1, the device selected and a write control active writes `wdata` to `addr` at that same edge. `burst_adv_n` is ignored on that edge.
- R6: When both strobes are low, only the processor strobe is acted on. The processor strobe is ignored while `sel_a_n`=1.
- R7: `all_wr_n`=0 writes all four byte lanes, whatever `lane_wr_n` and `lane_sel_n` are.
- R8: With `all_wr_n`=1 and `lane_wr_n`=0, lane i (bits 8i+7..8i) is written only where `lane_sel_n[i]`=0. The other lanes keep their contents.
- R9: After any edge that is decoded as a write, `dq_drive` is 0, even with `drv_en_n`=0.
- R10: An edge with both strobes high, while an access is active, continues that access. It is a write if a write control is active and a read otherwise. With `burst_adv_n`=0 the burst steps to its next address and that address is used. With `burst_adv_n`=1 the current address is used again.
- R11: The burst steps the two low address bits: `seq_linear`=1 gives (start+n) mod 4, and `seq_linear`=0 gives start XOR n. The upper address bits stay fixed for the whole burst.
- R12: `drv_en_n` acts on `dq_drive` without passing through any register. `drv_en_n`=1 forces `dq_drive` to 0 at once.
- R13: Sleep takes effect two edges after `doze` rises and ends two edges after it falls. While asleep, no access is started or continued, no write happens, `dq_drive` is 0, and the memory contents are kept.
- R14: After reset the block is idle and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| drv_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Sleep request, active high |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved (static strap) |
| addr | input | AW | Word address, sampled on strobe edges |
| wdata | input | NB*8 | Write data from the bus |
| rdata | output | NB*8 | Registered read data |
| dq_drive | output | 1 | Tri-state enable for the data pads |

## Verification
The bench targets the cycle in which the output mask applies. It checks that the mask covers the first read cycle after a deselect, after an idle cycle and after a write, and that it is gone one cycle later. A design without the mask would drive the bus one cycle early with stale data. A design that keeps the mask too long would lose the first word of the burst.

Processor-strobe starts are given an active write control on purpose. A design that honoured the write on the first edge would corrupt the word that is read back later. Starts with both strobes low, and deselects through enable 1, check strobe priority. Four-beat bursts from a non-zero start, run in both orders, catch a wrong step function.

A write attempted while asleep, followed by a read-back after waking, shows whether the sleep gate really blocks the array.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int AW = 6,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_used
);
  logic [AW-CW-1:0] hi_q;
  logic [CW-1:0]    base_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_sel;

  function automatic logic [CW-1:0] lo_map(input logic [CW-1:0] b,
                                           input logic [CW-1:0] c,
                                           input logic lin);
    return lin ? (b + c) : (b ^ c);
  endfunction

  assign cnt_sel = step ? (cnt_q + CW'(1)) : cnt_q;

  always_comb begin
    if (load) addr_used = ext_addr;
    else      addr_used = {hi_q, lo_map(base_q, cnt_sel, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      hi_q   <= ext_addr[AW-1:CW];
      base_q <= ext_addr[CW-1:0];
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_sel;
    end
  end
endmodule

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_ctrl_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          cpu_stb_n,
  input  logic          ctl_stb_n,
  input  logic          burst_adv_n,
  input  logic          all_wr_n,
  input  logic          lane_wr_n,
  input  logic [NB-1:0] lane_sel_n,
  input  logic          active,
  input  logic          asleep,
  output cyc_e          nxt_cyc,
  output logic          load,
  output logic          step,
  output logic          wr_en,
  output logic [NB-1:0] wr_mask
);
  logic cpu_ok, any_stb, selected, wr_req;

  assign cpu_ok   = !cpu_stb_n && !sel_a_n;
  assign any_stb  = cpu_ok || !ctl_stb_n;
  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign wr_req   = !all_wr_n || !lane_wr_n;
  assign wr_mask  = !all_wr_n ? {NB{1'b1}} : (!lane_wr_n ? ~lane_sel_n : {NB{1'b0}});

  always_comb begin
    nxt_cyc = CYC_IDLE;
    load    = 1'b0;
    step    = 1'b0;
    wr_en   = 1'b0;
    if (asleep) begin
      nxt_cyc = CYC_IDLE;
    end else if (any_stb && !selected) begin
      nxt_cyc = CYC_IDLE;
    end else if (any_stb) begin
      load = 1'b1;
      if (!cpu_ok && wr_req) begin
        nxt_cyc = CYC_WRITE;
        wr_en   = 1'b1;
      end else begin
        nxt_cyc = CYC_READ;
      end
    end else if (active) begin
      step = !burst_adv_n;
      if (wr_req) begin
        nxt_cyc = CYC_WRITE;
        wr_en   = 1'b1;
      end else begin
        nxt_cyc = CYC_READ;
      end
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [NB-1:0]    wmask,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*LW-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [NB*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && wmask[g]) lane_mem[waddr] <= wdata[g*LW +: LW];
      if (re)             lane_q <= lane_mem[raddr];
    end

    assign rdata[g*LW +: LW] = lane_q;
  end
endmodule

// File: rtl/sram_sleep_gate.sv
module sram_sleep_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], sleep_req};
  end

  assign asleep = sh_q[STAGES-1];
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8,
  parameter int SLEEP_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             burst_adv_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [NB-1:0]    lane_sel_n,
  input  logic             drv_en_n,
  input  logic             doze,
  input  logic             seq_linear,
  input  logic [AW-1:0]    addr,
  input  logic [NB*LW-1:0] wdata,
  output logic [NB*LW-1:0] rdata,
  output logic             dq_drive
);
  localparam int DW = NB * LW;

  cyc_e          cyc_q, nxt_cyc;
  logic          asleep, load, step, wr_en;
  logic [NB-1:0] wr_mask;
  logic [AW-1:0] addr_used, rd_addr_q;
  logic          rd_pend_q, dvalid_q;
  logic [DW-1:0] arr_q;

  sram_sleep_gate #(.STAGES(SLEEP_STAGES)) u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_req(doze), .asleep(asleep)
  );

  sram_cycle_decode #(.NB(NB)) u_dec (
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .burst_adv_n(burst_adv_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .active(cyc_q != CYC_IDLE), .asleep(asleep),
    .nxt_cyc(nxt_cyc), .load(load), .step(step), .wr_en(wr_en), .wr_mask(wr_mask)
  );

  sram_burst_seq #(.AW(AW), .CW(2)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .linear(seq_linear),
    .ext_addr(addr), .addr_used(addr_used)
  );

  sram_byte_array #(.AW(AW), .NB(NB), .LW(LW)) u_arr (
    .clk(clk), .we(wr_en), .wmask(wr_mask), .waddr(addr_used), .wdata(wdata),
    .re(rd_pend_q), .raddr(rd_addr_q), .rdata(arr_q)
  );

  // Stage one registers the access; stage two reads the array into the output word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= CYC_IDLE;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      dvalid_q  <= 1'b0;
    end else begin
      cyc_q     <= nxt_cyc;
      rd_pend_q <= (nxt_cyc == CYC_READ);
      rd_addr_q <= addr_used;
      dvalid_q  <= rd_pend_q;
    end
  end

  assign rdata    = arr_q;
  // Output-enable pin stays combinational; the valid bit provides the first-cycle mask.
  assign dq_drive = !drv_en_n && (cyc_q == CYC_READ) && dvalid_q && !asleep;
endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk
  import sram_ctrl_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic cpu_stb_n,
  input logic ctl_stb_n,
  input logic all_wr_n,
  input logic lane_wr_n,
  input logic drv_en_n,
  input logic dq_drive,
  input cyc_e cyc_q,
  input logic asleep
);
  logic sel;
  assign sel = !sel_a_n && sel_b && !sel_c_n;

  // R1: a strobe seen while not selected floats the bus after that edge
  a_r1_desel_float: assert property (@(posedge clk) disable iff (!rst_n)
    (((!cpu_stb_n && !sel_a_n) || !ctl_stb_n) && !sel) |=> !dq_drive);

  // R9: a controller-strobe write floats the bus after its edge
  a_r9_write_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_stb_n && cpu_stb_n && sel && (!all_wr_n || !lane_wr_n)) |=> !dq_drive);

  // R3: no drive in the first read cycle after a non-read cycle
  a_r3_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_READ && $past(cyc_q) != CYC_READ) |-> !dq_drive);

  // R12: pin high means no drive
  a_r12_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_n |-> !dq_drive);

  // R13: nothing driven while asleep
  a_r13_sleep_float: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !dq_drive);
endmodule

bind sram_access_ctrl sram_access_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .all_wr_n(all_wr_n),
  .lane_wr_n(lane_wr_n), .drv_en_n(drv_en_n), .dq_drive(dq_drive),
  .cyc_q(cyc_q), .asleep(asleep)
);

// File: tb/sim_sram_access_ctrl.sv
module sim_sram_access_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a_n, sel_b, sel_c_n, cpu_stb_n, ctl_stb_n, burst_adv_n;
  logic        all_wr_n, lane_wr_n, drv_en_n, doze, seq_linear;
  logic [3:0]  lane_sel_n;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        dq_drive;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sram_access_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .burst_adv_n(burst_adv_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .drv_en_n(drv_en_n), .doze(doze), .seq_linear(seq_linear), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dq_drive(dq_drive)
  );

  localparam logic [3:0] K_RDC = 0, K_RDP = 1, K_PC = 2, K_WRC = 3, K_SUSP = 4,
                         K_CONT = 5, K_SUSPW = 6, K_DESEL = 7, K_DES1 = 8;

  typedef struct packed {
    logic [3:0]  kind;
    logic [5:0]  a;
    logic [31:0] d;
    logic [3:0]  mask;
    logic        oe_n;
    logic        lin;
    logic        exp_drv;
    logic [31:0] exp_q;
    logic [3:0]  req;
  } row_t;

  localparam int NROW = 25;
  localparam row_t TAB [NROW] = '{
    '{K_WRC,  6'h10, 32'h11223344, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0,        4'd9},  // R9
    '{K_WRC,  6'h11, 32'hAABBCCDD, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0,        4'd5},  // R5
    '{K_WRC,  6'h12, 32'h01020304, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0,        4'd5},  // R5
    '{K_WRC,  6'h13, 32'h55667788, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0,        4'd7},  // R7
    '{K_WRC,  6'h12, 32'hFFFFFFFF, 4'h5, 1'b0, 1'b0, 1'b0, 32'h0,        4'd8},  // R8
    '{K_DESEL,6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 32'h0,        4'd1},  // R1
    '{K_RDC,  6'h12, 32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 32'h0,        4'd3},  // R3
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b1, 32'h01FF03FF, 4'd8},  // R8
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b1, 32'h55667788, 4'd5},  // R5 (and R11 interleaved)
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b1, 32'h11223344, 4'd7},  // R7
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b1, 1'b0, 1'b0, 32'h0,        4'd12}, // R12
    '{K_SUSP, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b1, 32'h01FF03FF, 4'd10}, // R10
    '{K_RDP,  6'h13, 32'hDEADBEEF, 4'h0, 1'b0, 1'b0, 1'b1, 32'h01FF03FF, 4'd4},  // R4
    '{K_SUSPW,6'h00, 32'h0000A5A5, 4'h3, 1'b0, 1'b0, 1'b0, 32'h0,        4'd9},  // R9
    '{K_RDC,  6'h13, 32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 32'h0,        4'd3},  // R3
    '{K_SUSP, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b1, 32'h5566A5A5, 4'd4},  // R4
    '{K_PC,   6'h10, 32'h0,        4'hF, 1'b0, 1'b0, 1'b1, 32'h5566A5A5, 4'd6},  // R6
    '{K_SUSP, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b1, 32'h11223344, 4'd6},  // R6
    '{K_DES1, 6'h10, 32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 32'h0,        4'd1},  // R1
    '{K_SUSP, 6'h00, 32'h0,        4'h0, 1'b0, 1'b0, 1'b0, 32'h0,        4'd1},  // R1
    '{K_RDC,  6'h11, 32'h0,        4'h0, 1'b0, 1'b1, 1'b0, 32'h0,        4'd3},  // R3
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b0, 1'b1, 1'b1, 32'hAABBCCDD, 4'd11}, // R11
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b0, 1'b1, 1'b1, 32'h01FF03FF, 4'd2},  // R2
    '{K_CONT, 6'h00, 32'h0,        4'h0, 1'b0, 1'b1, 1'b1, 32'h5566A5A5, 4'd10}, // R10
    '{K_SUSP, 6'h00, 32'h0,        4'h0, 1'b0, 1'b1, 1'b1, 32'h11223344, 4'd11}  // R11
  };

  task automatic idle_pins();
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; burst_adv_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
  endtask

  task automatic wr_ctl(input logic [3:0] m);
    if (m == 4'hF) all_wr_n = 1'b0;
    else begin lane_wr_n = 1'b0; lane_sel_n = ~m; end
  endtask

  task automatic apply(input row_t r);
    idle_pins();
    addr = r.a; wdata = r.d; drv_en_n = r.oe_n; seq_linear = r.lin;
    case (r.kind)
      K_RDC:   begin ctl_stb_n = 1'b0; burst_adv_n = 1'b0; end
      K_RDP:   begin cpu_stb_n = 1'b0; burst_adv_n = 1'b0; all_wr_n = 1'b0; end
      K_PC:    begin cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; all_wr_n = 1'b0; end
      K_WRC:   begin ctl_stb_n = 1'b0; burst_adv_n = 1'b0; wr_ctl(r.mask); end
      K_CONT:  burst_adv_n = 1'b0;
      K_SUSPW: wr_ctl(r.mask);
      K_DESEL: begin ctl_stb_n = 1'b0; sel_b = 1'b0; end
      K_DES1:  begin ctl_stb_n = 1'b0; cpu_stb_n = 1'b0; sel_a_n = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic check(input logic exp_drv, input logic [31:0] exp_q, input int req);
    nchk++;
    if (dq_drive !== exp_drv || (exp_drv && rdata !== exp_q)) begin
      nfail++;
      $display("FAIL R%0d: drive=%b data=%h expected drive=%b data=%h",
               req, dq_drive, rdata, exp_drv, exp_q);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    idle_pins();
    drv_en_n = 1'b0; doze = 1'b0; seq_linear = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(1'b0, 32'h0, 14);  // R14 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 32'h0, 14);  // R14 after release, idle inputs

    for (int i = 0; i < NROW; i++) begin
      apply(TAB[i]);
      @(negedge clk);
      check(TAB[i].exp_drv, TAB[i].exp_q, int'(TAB[i].req));
    end

    // R12: output enable acts without a clock edge (suspended read of 0x10)
    idle_pins(); seq_linear = 1'b1;
    drv_en_n = 1'b1; #1;
    check(1'b0, 32'h0, 12);
    drv_en_n = 1'b0; #1;
    check(1'b1, 32'h11223344, 12);

    // R13: sleep blocks a write and a read, contents survive
    idle_pins(); ctl_stb_n = 1'b0; sel_b = 1'b0;   // deselect before sleeping
    @(negedge clk);
    doze = 1'b1;
    repeat (2) @(negedge clk);
    idle_pins(); ctl_stb_n = 1'b0; burst_adv_n = 1'b0; all_wr_n = 1'b0;
    addr = 6'h10; wdata = 32'h0BADF00D; drv_en_n = 1'b0;
    @(negedge clk);
    check(1'b0, 32'h0, 13);
    idle_pins(); ctl_stb_n = 1'b0; addr = 6'h10;
    @(negedge clk);
    idle_pins();
    @(negedge clk);
    check(1'b0, 32'h0, 13);  // R13 read attempt while asleep drives nothing
    doze = 1'b0;
    idle_pins(); ctl_stb_n = 1'b0; sel_b = 1'b0;
    repeat (2) @(negedge clk);
    idle_pins(); ctl_stb_n = 1'b0; addr = 6'h10;
    @(negedge clk);
    check(1'b0, 32'h0, 3);   // R3 first read after wake is masked
    idle_pins();
    @(negedge clk);
    check(1'b1, 32'h11223344, 13);  // R13 write during sleep was dropped

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end
endmodule